// File: doc/BRIEF.md
# Set/Clear GPIO Register Controller

This block drives four general-purpose pins from one 32-bit configuration word. Software never writes pin data or pin direction directly. Instead it writes ones into separate set and clear strobe fields, and the block applies those strobes to its held output data and output-enable state. A pin whose enable is off is left undriven, whatever data is held for it. The block also samples the pin levels through one register stage into a read-only field of the same word.

The host writes through a synchronous port with byte enables and reads the assembled word on `rd_data` at any time. The pad side gets a per-pin data bit and a per-pin enable bit to feed tristate buffers outside the block. Pin inputs are already synchronous to `clk`. Reading a strobe field returns the value last written to it, not the pin state it produced.

Top module: `sc_gpio_ctrl`

## Requirements
- R1: While `rst_n` is low and after its release, `pin_oe`, `pin_out` and every field of `rd_data` read 0, so every pin starts as an input.
- R2: A write with `wr_be[1]` high drives low each pin whose bit in 11:8 is 1, and drives high each pin whose bit in 15:12 is 1. The change appears on `pin_out` in the cycle after the write cycle.
- R3: A write with `wr_be[2]` high turns off the enable of each pin whose bit in 19:16 is 1, and turns on the enable of each pin whose bit in 23:20 is 1. The change appears on `pin_oe` in the cycle after the write.
- R4: A 0 in any set or clear bit leaves the matching data or enable state unchanged.
- R5: When the set bit and the clear bit of one pin are both 1 in the same write, clear takes priority. This holds for both data and enable.
- R6: `pin_out` is 0 for every pin whose enable is off. The held data is kept and appears again once the enable is turned back on.
- R7: Bits 15:8 and 23:16 of `rd_data` return the value last written to them in a write with the matching byte enable.
- R8: A byte whose enable is low during a write stores nothing and triggers no set or clear action. Byte 1 covers bits 15:8 and byte 2 covers bits 23:16.
- R9: Bits 7:0 and 27:24 of `rd_data` always read 0. Writes to bytes 0 and 3 have no effect, including writes to the input field 31:28.
- R10: Bits 31:28 of `rd_data` show the `pin_in` value sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Register write strobe for this cycle |
| wr_be | input | 4 | Byte enables of the write |
| wr_data | input | 32 | Write data word |
| rd_data | output | 32 | Assembled register word |
| pin_out | output | 4 | Output data toward the pads, 0 when the pin is not enabled |
| pin_oe | output | 4 | Output enable toward the pads, 1 means drive |
| pin_in | input | 4 | Pin levels from the pads |

## Verification
Set-only writes, mixed set and clear writes, and all-zero writes are applied to the data and enable fields. Together they separate a correct read-modify update from an update that overwrites the state or ignores zeros. Writes with set and clear both high on the same pin show which of the two wins. A disable followed by a re-enable shows whether held data survives while the pin is tristated. Partial byte-enable writes that carry all-ones data in the masked bytes, and pin patterns that change on alternate bits, show whether masking and the one-stage input sampling are applied at the right bytes and in the right cycle.

// File: rtl/sc_gpio_pkg.sv
package sc_gpio_pkg;
  localparam int GPIO_N   = 4;
  localparam int REG_W    = 32;
  localparam int BE_W     = REG_W / 8;
  // field positions inside the register word
  localparam int DCLR_LSB = 8;
  localparam int DSET_LSB = 12;
  localparam int ECLR_LSB = 16;
  localparam int ESET_LSB = 20;
  localparam int RSV_LSB  = 24;
  localparam int PIN_LSB  = 28;
  // byte lanes that carry the strobe fields
  localparam int DATA_BYTE = DCLR_LSB / 8;
  localparam int OE_BYTE   = ECLR_LSB / 8;

  typedef struct packed {
    logic [GPIO_N-1:0] set;
    logic [GPIO_N-1:0] clr;
  } strobe_pair_t;
endpackage

// File: rtl/sc_gpio_field.sv
module sc_gpio_field #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nx;

  always_comb begin
    q_nx = q;
    if (load) q_nx = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= q_nx;
  end
endmodule

// File: rtl/sc_gpio_setclr.sv
module sc_gpio_setclr #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         act,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] state
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic st_q, st_nx, st_en;

    // clear wins over set on the same bit
    always_comb begin
      st_en = act && (set[i] || clr[i]);
      st_nx = st_q;
      if (clr[i])      st_nx = 1'b0;
      else if (set[i]) st_nx = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     st_q <= 1'b0;
      else if (st_en) st_q <= st_nx;
    end

    assign state[i] = st_q;
  end
endmodule

// File: rtl/sc_gpio_insample.sv
module sc_gpio_insample #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] lvl_q
);
  logic [N-1:0] lvl_nx;

  always_comb lvl_nx = lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_nx;
  end
endmodule

// File: rtl/sc_gpio_ctrl.sv
module sc_gpio_ctrl
  import sc_gpio_pkg::*;
#(
  parameter int N = GPIO_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [BE_W-1:0]  wr_be,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic [N-1:0]     pin_out,
  output logic [N-1:0]     pin_oe,
  input  logic [N-1:0]     pin_in
);
  logic         data_wr, oe_wr;
  strobe_pair_t data_wv, oe_wv;
  strobe_pair_t data_rb, oe_rb;
  logic [N-1:0] data_q, oe_q, in_q;
  logic         unused_lanes;

  assign data_wr = wr_en && wr_be[DATA_BYTE];
  assign oe_wr   = wr_en && wr_be[OE_BYTE];

  assign data_wv.clr = wr_data[DCLR_LSB +: N];
  assign data_wv.set = wr_data[DSET_LSB +: N];
  assign oe_wv.clr   = wr_data[ECLR_LSB +: N];
  assign oe_wv.set   = wr_data[ESET_LSB +: N];

  assign unused_lanes = ^{wr_data[7:0], wr_data[REG_W-1:RSV_LSB],
                          wr_be[0], wr_be[BE_W-1]};

  // last-written strobe values for readback
  sc_gpio_field #(.W(N)) u_dclr (.clk(clk), .rst_n(rst_n), .load(data_wr),
                                 .din(data_wv.clr), .q(data_rb.clr));
  sc_gpio_field #(.W(N)) u_dset (.clk(clk), .rst_n(rst_n), .load(data_wr),
                                 .din(data_wv.set), .q(data_rb.set));
  sc_gpio_field #(.W(N)) u_eclr (.clk(clk), .rst_n(rst_n), .load(oe_wr),
                                 .din(oe_wv.clr), .q(oe_rb.clr));
  sc_gpio_field #(.W(N)) u_eset (.clk(clk), .rst_n(rst_n), .load(oe_wr),
                                 .din(oe_wv.set), .q(oe_rb.set));

  // held pin state
  sc_gpio_setclr #(.N(N)) u_data (.clk(clk), .rst_n(rst_n), .act(data_wr),
                                  .set(data_wv.set), .clr(data_wv.clr),
                                  .state(data_q));
  sc_gpio_setclr #(.N(N)) u_oe   (.clk(clk), .rst_n(rst_n), .act(oe_wr),
                                  .set(oe_wv.set), .clr(oe_wv.clr),
                                  .state(oe_q));

  sc_gpio_insample #(.N(N)) u_in (.clk(clk), .rst_n(rst_n), .lvl(pin_in),
                                  .lvl_q(in_q));

  always_comb begin
    rd_data                  = '0;
    rd_data[DCLR_LSB +: N]   = data_rb.clr;
    rd_data[DSET_LSB +: N]   = data_rb.set;
    rd_data[ECLR_LSB +: N]   = oe_rb.clr;
    rd_data[ESET_LSB +: N]   = oe_rb.set;
    rd_data[PIN_LSB  +: N]   = in_q;
  end

  assign pin_oe  = oe_q;
  assign pin_out = data_q & oe_q;
endmodule

// File: rtl/sc_gpio_ctrl_chk.sv
module sc_gpio_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [3:0]  wr_be,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic [3:0]  pin_out,
  input logic [3:0]  pin_oe,
  input logic [3:0]  pin_in
);
  logic pv;
  logic unused_chk;
  assign unused_chk = ^{wr_data[7:0], wr_data[31:24], wr_be[0], wr_be[3]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pv <= 1'b0;
    else        pv <= 1'b1;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |-> (pin_oe == 4'h0 && pin_out == 4'h0));

  // R2
  data_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_be[1] && !wr_be[2]) |=> ((pin_out & $past(wr_data[11:8])) == 4'h0));

  // R2
  data_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_be[1] && !wr_be[2]) |=>
      ((pin_out & $past(wr_data[15:12] & ~wr_data[11:8] & pin_oe)) ==
        $past(wr_data[15:12] & ~wr_data[11:8] & pin_oe)));

  // R3
  oe_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_be[2]) |=>
      ((pin_oe & $past(wr_data[23:20] & ~wr_data[19:16])) ==
        $past(wr_data[23:20] & ~wr_data[19:16])));

  // R5
  oe_clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_be[2]) |=> ((pin_oe & $past(wr_data[19:16])) == 4'h0));

  // R6
  undriven_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == 4'h0);

  // R7
  data_rb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_be[1]) |=> (rd_data[15:8] == $past(wr_data[15:8])));

  // R7
  oe_rb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_be[2]) |=> (rd_data[23:16] == $past(wr_data[23:16])));

  // R8
  masked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (wr_be[1] || wr_be[2])) |=>
      ($stable(pin_oe) && $stable(pin_out) && $stable(rd_data[23:8])));

  // R9
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[27:24] == 4'h0 && rd_data[7:0] == 8'h00));

  // R10
  in_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pv |-> (rd_data[31:28] == $past(pin_in)));
endmodule

bind sc_gpio_ctrl sc_gpio_ctrl_chk u_chk (.*);

// File: tb/sim_sc_gpio_ctrl.sv
module sim_sc_gpio_ctrl;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_be;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic [3:0]  pin_out;
  logic [3:0]  pin_oe;
  logic [3:0]  pin_in;

  sc_gpio_ctrl u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be),
                   .wr_data(wr_data), .rd_data(rd_data), .pin_out(pin_out),
                   .pin_oe(pin_oe), .pin_in(pin_in));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {
    int          due;
    logic [31:0] rd;
    logic [3:0]  po;
    logic [3:0]  oe;
    string       tag;
  } exp_t;

  exp_t q[$];
  exp_t it;
  int cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;
  bit over = 0;

  // bench model state
  logic [3:0] m_dclr = 0, m_dset = 0, m_eclr = 0, m_eset = 0;
  logic [3:0] m_data = 0, m_oe = 0, m_in = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] mk(input logic [3:0] dc, ds, ec, es,
                                     input logic [7:0] b0,
                                     input logic [3:0] rs, ins);
    return {ins, rs, es, ec, ds, dc, b0};
  endfunction

  task automatic do_op(input logic we, input logic [3:0] be,
                       input logic [31:0] d, input logic [3:0] pins,
                       input string tag);
    exp_t e;
    wr_en = we; wr_be = be; wr_data = d; pin_in = pins;
    if (we && be[1]) begin
      m_dclr = d[11:8]; m_dset = d[15:12];
      m_data = (m_data | m_dset) & ~m_dclr;
    end
    if (we && be[2]) begin
      m_eclr = d[19:16]; m_eset = d[23:20];
      m_oe = (m_oe | m_eset) & ~m_eclr;
    end
    m_in = pins;
    e.due = cyc + 1;
    e.rd  = {m_in, 4'h0, m_eset, m_eclr, m_dset, m_dclr, 8'h00};
    e.po  = m_data & m_oe;
    e.oe  = m_oe;
    e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == cyc) begin
      it = q.pop_front();
      n_cmp++;
      if (rd_data !== it.rd || pin_out !== it.po || pin_oe !== it.oe) begin
        n_bad++;
        $display("FAIL %s: rd=%h out=%b oe=%b expected rd=%h out=%b oe=%b",
                 it.tag, rd_data, pin_out, pin_oe, it.rd, it.po, it.oe);
      end
    end
  end

  initial begin
    #(20 * 5000);
    if (!over) begin
      n_bad++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_be = 4'h0; wr_data = '0; pin_in = 4'h0;
    repeat (3) @(negedge clk);
    // R1: outputs low while in reset
    n_cmp++;
    if (pin_oe !== 4'h0 || pin_out !== 4'h0 || rd_data !== 32'h0) begin
      n_bad++;
      $display("FAIL R1: rd=%h out=%b oe=%b expected all zero", rd_data, pin_out, pin_oe);
    end
    rst_n = 1'b1;
    do_op(0, 4'h0, 32'h0, 4'h0, "R1 after reset");
    // R3 enable pins 0,1
    do_op(1, 4'b0100, mk(0, 0, 0, 4'b0011, 0, 0, 0), 4'h0, "R3 enable set");
    // R2 set data 0,2; only pin 0 enabled
    do_op(1, 4'b0010, mk(0, 4'b0101, 0, 0, 0, 0, 0), 4'h0, "R2 data set");
    // R2/R3 mixed set and clear
    do_op(1, 4'b0110, mk(4'b0001, 4'b1010, 0, 4'b1100, 0, 0, 0), 4'h0, "R2 mixed");
    // R4 zero write leaves state, R7 readback becomes zero
    do_op(1, 4'b0110, mk(0, 0, 0, 0, 0, 0, 0), 4'h0, "R4 zero write");
    // R5 clear wins on same pin
    do_op(1, 4'b0110, mk(4'b0100, 4'b0100, 4'b1000, 4'b1000, 0, 0, 0), 4'h0, "R5 clear wins");
    // R8/R9 masked bytes carry all ones
    do_op(1, 4'b1001, 32'hFFFF_FFFF, 4'h0, "R8 masked bytes");
    do_op(1, 4'b0001, 32'hFFFF_FFFF, 4'h0, "R9 byte0 write");
    // R6 disable all, data held
    do_op(1, 4'b0100, mk(4'hF, 4'hF, 4'hF, 0, 0, 0, 0), 4'h0, "R6 disable");
    do_op(1, 4'b0100, mk(0, 0, 0, 4'hF, 0, 0, 0), 4'h0, "R6 re-enable");
    // R7 readback of a fresh data write
    do_op(1, 4'b0010, mk(4'b0011, 4'b0000, 0, 0, 0, 0, 0), 4'h0, "R7 readback");
    // R10 input sampling
    do_op(0, 4'h0, 32'h0, 4'b1010, "R10 pins 1010");
    do_op(0, 4'h0, 32'h0, 4'b0101, "R10 pins 0101");
    do_op(1, 4'b1000, 32'h0000_0000, 4'b1111, "R9 input field not writable");
    do_op(1, 4'b1111, mk(4'b1000, 4'b0111, 4'b0001, 4'b0000, 8'hFF, 4'hF, 4'h0),
          4'b0011, "R2 full word");
    do_op(0, 4'h0, 32'h0, 4'b0011, "R8 idle hold");
    @(negedge clk);
    #1;
    if (q.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard: %0d left expected 0", q.size());
    end
    over = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule